// File: doc/BRIEF.md
# Top-of-Memory Flash Window Decoder

This block sits on the direct-read path between the processor and a boot flash device. Each processor read aimed at the top of the 32-bit address space is turned into a linear flash address. The block then decides whether the read may return the flash byte or must return all-ones. It claims only the top 16 MB of the address space. A read below that range is flagged as not claimed and always reads as all-ones.

The visibility rule depends on a mode that is fixed once per reset. In the first clock after reset is released, a controller state machine compares the signature word supplied from flash against the valid-descriptor value. A match puts the block in descriptor mode. In that mode only the protected boot region is readable: it is given as an inclusive range of 4 KB pages and must also lie inside the window that ends at the 4 GB boundary. Any other value puts the block in flat mode. In flat mode the whole device is readable, and a device smaller than 16 MB repeats through the claimed range.

The state machine has three states. SAMPLE is entered at reset. From SAMPLE it takes the transition SAMPLE_TO_DESC when the signature matches and SAMPLE_TO_FLAT otherwise. DESC and FLAT are terminal states, and the block leaves them only through reset. Each response is registered one cycle after its read strobe. The data byte for the returned address comes back from the flash side in the same cycle and is passed through or replaced by all-ones.

Top module: `flash_window_decoder`

## Requirements
- R1: Reads whose strobe is sampled in the SAMPLE state (the first clock edge after reset release) are answered with pass low and data 0xFF.
- R2: A signature word equal to 0x0FF0A55A at the SAMPLE edge selects descriptor mode. Any other value, such as 0x0FF0A55B, selects flat mode.
- R3: Once DESC or FLAT is reached, the mode stays fixed until the next reset, whatever the signature input does afterwards.
- R4: A read whose address bits [31:24] are not all ones is answered with unclaimed high, pass low, flash address 0 and data 0xFF.
- R5: The flash address is bits [23:0] of the read address masked to log2(size) bits. Size code 0,1,2,3,4 means 1,2,4,8,16 MB, and codes above 4 are treated as 16 MB.
- R6: In flat mode every claimed read passes, so a device smaller than 16 MB aliases through the top 16 MB.
- R7: In descriptor mode a claimed read passes only when two conditions hold. Address bits [23:0] must be at least 16 MB minus the size, and flash address bits [23:12] must lie between the base and limit page numbers, both ends inclusive.
- R8: The read data equals the flash data input while a valid response has pass high, and is 0xFF otherwise.
- R9: Every read strobe produces exactly one valid response, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Direct read strobe |
| rd_addr | input | 32 | Processor read address |
| size_sel | input | 3 | Flash size code (0 = 1 MB … 4 = 16 MB) |
| sig_word | input | 32 | Signature word read from flash |
| rgn_base | input | 12 | First page (4 KB) of the boot region |
| rgn_limit | input | 12 | Last page (4 KB) of the boot region, inclusive |
| flash_rdata | input | 8 | Flash byte at rsp_addr |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 24 | Linear flash address |
| rsp_pass | output | 1 | Read may return flash data |
| rsp_unclaimed | output | 1 | Address lies outside the top 16 MB |
| rd_data | output | 8 | Returned data byte |

## Verification
The assertions assume that the region bounds and the size code stay stable for the cycle in which a read is issued. They also assume that the flash data input belongs to the address currently presented. The bench changes region bounds, size and signature only while no read is in flight. Its flash model computes the byte purely from the presented address. The signature is changed only while reset is held, except in the one scenario that checks R3 on purpose.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'd0,
        MODE_DESC   = 2'd1,
        MODE_FLAT   = 2'd2
    } mode_e;

    localparam logic [31:0] SIG_VALID = 32'h0FF0_A55A;
endpackage

// File: rtl/fwd_mode_fsm.sv
module fwd_mode_fsm
    import fwd_pkg::*;
#(
    parameter int SIG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] sig_word,
    output mode_e            mode_q,
    output logic             mode_known,
    output logic             mode_desc
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SAMPLE: mode_d = (sig_word == SIG_VALID[SIG_W-1:0]) ? MODE_DESC : MODE_FLAT;
            MODE_DESC:   mode_d = MODE_DESC;
            MODE_FLAT:   mode_d = MODE_FLAT;
            default:     mode_d = MODE_SAMPLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SAMPLE;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_known = 1'b0;
        mode_desc  = 1'b0;
        unique case (mode_q)
            MODE_SAMPLE: begin mode_known = 1'b0; mode_desc = 1'b0; end
            MODE_DESC:   begin mode_known = 1'b1; mode_desc = 1'b1; end
            MODE_FLAT:   begin mode_known = 1'b1; mode_desc = 1'b0; end
            default:     begin mode_known = 1'b0; mode_desc = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fwd_addr_map.sv
module fwd_addr_map #(
    parameter int MAX_LOG2 = 24,
    parameter int MIN_LOG2 = 20,
    parameter int SEL_W    = 3
) (
    input  logic [MAX_LOG2-1:0] addr_low,
    input  logic [SEL_W-1:0]    size_sel,
    output logic [MAX_LOG2-1:0] flash_addr,
    output logic                in_window
);
    localparam int NUM_SIZES = MAX_LOG2 - MIN_LOG2 + 1;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_SIZES - 1);

    logic [MAX_LOG2-1:0] mask_tbl [NUM_SIZES];
    logic [SEL_W-1:0]    sel_c;
    logic [MAX_LOG2-1:0] mask;

    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_mask
        assign mask_tbl[i] = ~({MAX_LOG2{1'b1}} << (MIN_LOG2 + i));
    end

    always_comb begin
        sel_c      = (size_sel > SEL_MAX) ? SEL_MAX : size_sel;
        mask       = mask_tbl[sel_c];
        flash_addr = addr_low & mask;
        in_window  = &(addr_low | mask);
    end
endmodule

// File: rtl/fwd_region_check.sv
module fwd_region_check #(
    parameter int MAX_LOG2   = 24,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [MAX_LOG2-1:0]            flash_addr,
    input  logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_base,
    input  logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_limit,
    output logic                           rgn_hit
);
    logic [MAX_LOG2-PAGE_SHIFT-1:0] page;

    always_comb begin
        page    = flash_addr[MAX_LOG2-1:PAGE_SHIFT];
        rgn_hit = (page >= rgn_base) && (page <= rgn_limit);
    end
endmodule

// File: rtl/flash_window_decoder.sv
module flash_window_decoder
    import fwd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_LOG2   = 24,
    parameter int MIN_LOG2   = 20,
    parameter int SEL_W      = 3,
    parameter int PAGE_SHIFT = 12,
    parameter int DATA_W     = 8,
    parameter int SIG_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [SEL_W-1:0]               size_sel,
    input  logic [SIG_W-1:0]               sig_word,
    input  logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_base,
    input  logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_limit,
    input  logic [DATA_W-1:0]              flash_rdata,
    output logic                           rsp_valid,
    output logic [MAX_LOG2-1:0]            rsp_addr,
    output logic                           rsp_pass,
    output logic                           rsp_unclaimed,
    output logic [DATA_W-1:0]              rd_data
);
    mode_e               mode_q;
    logic                mode_known;
    logic                mode_desc;
    logic [MAX_LOG2-1:0] flash_addr;
    logic                in_window;
    logic                rgn_hit;
    logic                claimed;
    logic                pass_c;

    fwd_mode_fsm #(.SIG_W(SIG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_word   (sig_word),
        .mode_q     (mode_q),
        .mode_known (mode_known),
        .mode_desc  (mode_desc)
    );

    fwd_addr_map #(
        .MAX_LOG2 (MAX_LOG2),
        .MIN_LOG2 (MIN_LOG2),
        .SEL_W    (SEL_W)
    ) u_map (
        .addr_low   (rd_addr[MAX_LOG2-1:0]),
        .size_sel   (size_sel),
        .flash_addr (flash_addr),
        .in_window  (in_window)
    );

    fwd_region_check #(
        .MAX_LOG2   (MAX_LOG2),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_rgn (
        .flash_addr (flash_addr),
        .rgn_base   (rgn_base),
        .rgn_limit  (rgn_limit),
        .rgn_hit    (rgn_hit)
    );

    always_comb begin
        claimed = &rd_addr[ADDR_W-1:MAX_LOG2];
        if (!mode_known)   pass_c = 1'b0;
        else if (mode_desc) pass_c = in_window && rgn_hit;
        else               pass_c = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_addr      <= '0;
            rsp_pass      <= 1'b0;
            rsp_unclaimed <= 1'b0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_addr      <= claimed ? flash_addr : '0;
                rsp_pass      <= claimed && pass_c;
                rsp_unclaimed <= !claimed;
            end else begin
                rsp_pass      <= 1'b0;
                rsp_unclaimed <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = (rsp_valid && rsp_pass) ? flash_rdata : {DATA_W{1'b1}};
    end
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker
    import fwd_pkg::*;
#(
    parameter int MAX_LOG2   = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int DATA_W     = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           rd_en,
    input logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_base,
    input logic [MAX_LOG2-PAGE_SHIFT-1:0] rgn_limit,
    input logic                           rsp_valid,
    input logic [MAX_LOG2-1:0]            rsp_addr,
    input logic                           rsp_pass,
    input logic                           rsp_unclaimed,
    input logic [DATA_W-1:0]              rd_data,
    input mode_e                          mode_q
);
    AST_SAMPLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_SAMPLE) |-> !rsp_pass); // R1

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_SAMPLE) |=> $stable(mode_q)); // R3

    AST_UNCLAIMED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_unclaimed |-> (!rsp_pass && rsp_addr == '0)); // R4

    AST_DESC_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pass && $past(mode_q) == MODE_DESC) |->
        (rsp_addr[MAX_LOG2-1:PAGE_SHIFT] >= $past(rgn_base) &&
         rsp_addr[MAX_LOG2-1:PAGE_SHIFT] <= $past(rgn_limit))); // R7

    AST_BLOCK_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_pass |-> (rd_data == {DATA_W{1'b1}})); // R8

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid); // R9

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid); // R9
endmodule

bind flash_window_decoder fwd_checker #(
    .MAX_LOG2   (MAX_LOG2),
    .PAGE_SHIFT (PAGE_SHIFT),
    .DATA_W     (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rgn_base      (rgn_base),
    .rgn_limit     (rgn_limit),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_pass      (rsp_pass),
    .rsp_unclaimed (rsp_unclaimed),
    .rd_data       (rd_data),
    .mode_q        (mode_q)
);

// File: tb/flash_window_decoder_tb_top.sv
module flash_window_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SIG_OK  = 32'h0FF0_A55A;
    localparam logic [31:0] SIG_BAD = 32'h0FF0_A55B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [2:0]  size_sel = 3'd4;
    logic [31:0] sig_word = '0;
    logic [11:0] rgn_base = '0;
    logic [11:0] rgn_limit = '0;
    logic [7:0]  flash_rdata;
    logic        rsp_valid;
    logic [23:0] rsp_addr;
    logic        rsp_pass;
    logic        rsp_unclaimed;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // flash model: byte is a fixed function of the presented address
    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h5C;
    endfunction
    assign flash_rdata = fbyte(rsp_addr);

    flash_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .size_sel(size_sel), .sig_word(sig_word), .rgn_base(rgn_base),
        .rgn_limit(rgn_limit), .flash_rdata(flash_rdata),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_pass(rsp_pass),
        .rsp_unclaimed(rsp_unclaimed), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mask_of(input logic [2:0] sel);
        int lg = 20 + ((sel > 3'd4) ? 4 : int'(sel));
        return 24'((32'd1 << lg) - 1);
    endfunction

    // one read; outputs checked at the negedge after the response edge
    task automatic rd_chk(input logic [31:0] a, input bit exp_pass, input bit exp_uncl,
                          input logic [23:0] exp_fa, input string tag);
        logic [7:0] exp_d;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        exp_d = exp_pass ? fbyte(exp_fa) : 8'hFF;
        chk(rsp_valid == 1'b1, {tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_pass == exp_pass, {tag, " pass"}, 32'(rsp_pass), 32'(exp_pass));
        chk(rsp_unclaimed == exp_uncl, {tag, " R4 unclaimed"}, 32'(rsp_unclaimed), 32'(exp_uncl));
        chk(rsp_addr == exp_fa, {tag, " R5 addr"}, 32'(rsp_addr), 32'(exp_fa));
        chk(rd_data == exp_d, {tag, " R8 data"}, 32'(rd_data), 32'(exp_d));
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R9 single"}, 32'(rsp_valid), 32'd0);
    endtask

    // reset with a signature; a read is issued in the SAMPLE cycle (R1)
    task automatic do_reset(input logic [31:0] sig);
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; sig_word = sig;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && rd_data == 8'hFF, "R1 reset state", {rsp_valid, 23'd0, rd_data}, 32'hFF);
        rst_n = 1'b1; rd_en = 1'b1; rd_addr = 32'hFFFF_F000;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rsp_valid == 1'b1 && rsp_pass == 1'b0, "R1 sample blocks pass", 32'(rsp_pass), 32'd0);
        chk(rd_data == 8'hFF, "R1 sample data", 32'(rd_data), 32'hFF);
        @(negedge clk);
    endtask

    task automatic t_flat_alias;
        size_sel = 3'd2; rgn_base = 12'h010; rgn_limit = 12'h010;
        do_reset(SIG_BAD);
        rd_chk(32'hFFC0_1234, 1, 0, 24'h001234, "R2 R6 flat top copy");
        rd_chk(32'hFF40_1234, 1, 0, 24'h001234, "R6 flat alias 1");
        rd_chk(32'hFF00_1234, 1, 0, 24'h001234, "R6 flat alias 2");
        rd_chk(32'hFFFF_FFFF, 1, 0, 24'h3FFFFF, "R5 flat last byte");
    endtask

    task automatic t_desc_bounds;
        size_sel = 3'd4; rgn_base = 12'h003; rgn_limit = 12'h005;
        do_reset(SIG_OK);
        rd_chk(32'hFF00_3000, 1, 0, 24'h003000, "R2 R7 base edge");
        rd_chk(32'hFF00_5FFF, 1, 0, 24'h005FFF, "R7 limit edge");
        rd_chk(32'hFF00_2FFF, 0, 0, 24'h002FFF, "R7 below base");
        rd_chk(32'hFF00_6000, 0, 0, 24'h006000, "R7 above limit");
    endtask

    task automatic t_desc_window;
        size_sel = 3'd2; rgn_base = 12'h003; rgn_limit = 12'h003;
        do_reset(SIG_OK);
        rd_chk(32'hFFC0_3010, 1, 0, 24'h003010, "R7 in window");
        rd_chk(32'hFF00_3010, 0, 0, 24'h003010, "R7 below window");
    endtask

    task automatic t_unclaimed;
        rd_chk(32'hFEFF_FFFF, 0, 1, 24'h000000, "R4 just below");
        rd_chk(32'h0000_0000, 0, 1, 24'h000000, "R4 low memory");
    endtask

    task automatic t_mode_held;
        size_sel = 3'd4; rgn_base = 12'h001; rgn_limit = 12'h001;
        do_reset(SIG_BAD);
        @(negedge clk);
        sig_word = SIG_OK;
        repeat (3) @(negedge clk);
        rd_chk(32'hFF80_0000, 1, 0, 24'h800000, "R3 flat kept");
        size_sel = 3'd7;
        rd_chk(32'hFF12_3456, 1, 0, 24'h123456 & mask_of(3'd7), "R5 code over 4");
        size_sel = 3'd0;
        rd_chk(32'hFF12_3456, 1, 0, 24'h123456 & mask_of(3'd0), "R5 1MB mask");
    endtask

    initial begin
        t_flat_alias();
        t_desc_bounds();
        t_unclaimed();
        t_desc_window();
        t_mode_held();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule